// File: doc/BRIEF.md
# Selectable-Mode Phase-Frequency Detector

This block is the digital core of a synthesizer's phase comparison path. It counts the reference oscillator clock down by a programmable ratio to produce the comparison-rate reference. It registers that divided reference on the undivided reference clock and compares it with the divided feedback pulse in a three-state phase-frequency detector. The detector drives the sourcing (up) and sinking (down) enables of an external charge pump and also puts out a two-bit code for the current level.

A mode input selects how the current code responds when both enables are on at once. In linear mode the code always asks for full current. In piecewise-linear mode the code drops to half current for every cycle in which the sourcing and sinking enables overlap. The divide ratio and the mode are static configuration inputs that a serial control interface elsewhere in the chip sets. With a 26 MHz reference, a ratio of 65 gives a 400 kHz comparison rate.

Top module: `pfd_modesel`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `ref_div`, `up` and `dn` are 0 and `cur_code` is 2'b00.
- R2: `ref_div` is high for exactly one `clk` cycle and repeats every `rdiv_val` cycles (`rdiv_val` must be 2 or more). A value of 65 gives a period of 65 cycles.
- R3: `ref_div` is a registered output. `up` goes high on the first clock edge at which `ref_div` is high.
- R4: A rising edge on `fb_pulse` (low in one cycle, high in the next) sets `dn` at that same clock edge. Holding `fb_pulse` high does not set `dn` again.
- R5: Once `up` and `dn` are both high, they both go low together after exactly `RST_DLY` cycles of overlap. Overlap never lasts longer than that.
- R6: When the reference leads the feedback by k cycles, `up` is high for k+`RST_DLY` cycles and `dn` is high for `RST_DLY` cycles.
- R7: When the feedback leads the reference by k cycles, `dn` is high for k+`RST_DLY` cycles and `up` is high for `RST_DLY` cycles.
- R8: With zero phase error, `up` and `dn` rise in the same cycle and both stay high for `RST_DLY` cycles.
- R9: `cur_code` is 2'b00 (off) when neither enable is high. It is 2'b01 (half) when both are high and `mode_pwl` is 1. It is 2'b10 (full) in every other case, including overlap when `mode_pwl` is 0.
- R10: A reference pulse that arrives while `up` is already high is ignored. `up` stays high, without a break, until the feedback edge arrives and the overlap clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference oscillator clock, also the detector's timing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rdiv_val | input | DIV_W | Reference divide ratio, 2 or more |
| mode_pwl | input | 1 | 1 selects piecewise-linear current, 0 selects linear |
| fb_pulse | input | 1 | Divided feedback signal, synchronous to clk, detected on its rising edge |
| ref_div | output | 1 | Divided and retimed reference pulse |
| up | output | 1 | Sourcing charge-pump enable |
| dn | output | 1 | Sinking charge-pump enable |
| cur_code | output | 2 | Current level: 00 off, 01 half, 10 full |

## Verification
`up` follows a `ref_div` pulse by one clock edge. `dn` follows the cycle in which `fb_pulse` is first driven high by one edge. The pair clears `RST_DLY` edges after they first overlap, and `cur_code` changes in the same cycle as the enables. Each scenario task drives its inputs at the falling edge and samples all outputs at the next falling edge. It numbers the cycles from the falling edge at which `ref_div` is seen high. That numbering lets the task predict the first high cycle and the width of each enable, and check `cur_code` against the sampled enables in every cycle.

// File: rtl/pfd_modesel.sv
module pfd_modesel #(
  parameter int DIV_W   = 8,
  parameter int RST_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] rdiv_val,
  input  logic             mode_pwl,
  input  logic             fb_pulse,
  output logic             ref_div,
  output logic             up,
  output logic             dn,
  output logic [1:0]       cur_code
);

  localparam int OW = $clog2(RST_DLY + 1);

  logic [DIV_W-1:0] cnt;
  logic             cnt_wrap;
  logic             fb_q;
  logic             fb_edge;
  logic             both;
  logic [OW-1:0]    ovl;
  logic             clr;

  assign cnt_wrap = (cnt >= rdiv_val - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      ref_div <= 1'b0;
    end else begin
      cnt     <= cnt_wrap ? '0 : cnt + 1'b1;
      ref_div <= cnt_wrap;
    end
  end

  assign fb_edge = fb_pulse & ~fb_q;
  assign both    = up & dn;
  assign clr     = both && (ovl == OW'(RST_DLY - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fb_q <= 1'b0;
      up   <= 1'b0;
      dn   <= 1'b0;
      ovl  <= '0;
    end else begin
      fb_q <= fb_pulse;
      up   <= clr ? 1'b0 : (up | ref_div);
      dn   <= clr ? 1'b0 : (dn | fb_edge);
      ovl  <= (both && !clr) ? ovl + 1'b1 : '0;
    end
  end

  assign cur_code = !(up | dn)        ? 2'b00 :
                    (both && mode_pwl) ? 2'b01 : 2'b10;

  logic [OW:0] both_run;
  always_ff @(posedge clk) begin
    if (!rst_n) both_run <= '0;
    else        both_run <= both ? both_run + 1'b1 : '0;
  end

  AST_BOTH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn) |-> (both_run < (OW+1)'(RST_DLY)));  // R5
  AST_UP_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_div && !(up && dn)) |=> up);  // R3
  AST_DN_ON_FB: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && !fb_q && !(up && dn)) |=> dn);  // R4
  AST_REF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_div |=> !ref_div);  // R2
  AST_CLEAR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up) |-> $fell(dn));  // R5

endmodule

// File: tb/pfd_modesel_tb.sv
module pfd_modesel_tb;
  localparam int DIV_W = 8;
  localparam int D     = 2;
  localparam int R     = 65;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] rdiv_val = DIV_W'(R);
  logic             mode_pwl = 1'b0;
  logic             fb_pulse = 1'b0;
  logic             ref_div, up, dn;
  logic [1:0]       cur_code;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pfd_modesel #(.DIV_W(DIV_W), .RST_DLY(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .rdiv_val(rdiv_val), .mode_pwl(mode_pwl),
    .fb_pulse(fb_pulse), .ref_div(ref_div), .up(up), .dn(dn), .cur_code(cur_code));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sync_ref();
    while (ref_div !== 1'b1) @(negedge clk);
  endtask

  // cycle 0 = negedge where ref_div is seen; fb driven high at fa (len fw) and fb_b
  task automatic run_window(string tag, int len, int fa, int fw, int fb_b, int start,
                            int exp_up, int exp_dn, int exp_up_first, int exp_dn_first);
    int n_up = 0, n_dn = 0, n_half = 0, bad_code = 0, run = 0, max_run = 0;
    int up_first = -1, dn_first = -1;
    logic [1:0] ec;
    sync_ref();
    for (int i = 0; i <= len; i++) begin
      if (i >= start) begin
        if (up) begin n_up++; if (up_first < 0) up_first = i; end
        if (dn) begin n_dn++; if (dn_first < 0) dn_first = i; end
        if (up && dn) begin run++; if (run > max_run) max_run = run; end else run = 0;
        ec = (!up && !dn) ? 2'b00 : (up && dn && mode_pwl) ? 2'b01 : 2'b10;
        if (cur_code !== ec) bad_code++;
        if (cur_code === 2'b01) n_half++;
      end
      fb_pulse = ((i >= fa && i < fa + fw) || i == fb_b) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    fb_pulse = 1'b0;
    $display("scenario %s mode_pwl=%0b", tag, mode_pwl);
    chk({"R6/R7/R8 up width ", tag}, n_up, exp_up);
    chk({"R6/R7/R8 dn width ", tag}, n_dn, exp_dn);
    chk({"R3 up first cycle ", tag}, up_first, exp_up_first);
    chk({"R4 dn first cycle ", tag}, dn_first, exp_dn_first);
    chk({"R5 overlap length ", tag}, max_run, D);
    chk({"R9 code per cycle ", tag}, bad_code, 0);
    chk({"R9 half-code cycles ", tag}, n_half, mode_pwl ? D : 0);
  endtask

  task automatic t_lead(int k);   // R6
    run_window("lead", 30, k, 1, -1, 0, k + D, D, 1, k + 1);
  endtask

  task automatic t_lag(int k);    // R7
    run_window("lag", R + 20, 0, 1, R - k, D + 3, D, k + D, R + 1, R - k + 1);
  endtask

  task automatic t_zero();        // R8
    run_window("zero", 30, 0, 1, -1, 0, D, D, 1, 1);
  endtask

  task automatic t_idle();        // R10 and R4 held high
    int f = 2 * R + 5;
    run_window("idle", f + 20, f, 3, -1, 0, f + D, D, 1, f + 1);
  endtask

  task automatic t_reset();       // R1
    @(negedge clk);
    chk("R1 up in reset", up, 0);
    chk("R1 dn in reset", dn, 0);
    chk("R1 ref_div in reset", ref_div, 0);
    chk("R1 code in reset", cur_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 up after reset", up, 0);
    chk("R1 code after reset", cur_code, 0);
  endtask

  task automatic t_period(int ratio);  // R2
    int gap = 0;
    rdiv_val = DIV_W'(ratio);
    repeat (3 * R) @(negedge clk);
    sync_ref();
    @(negedge clk);
    chk("R2 ref_div width", ref_div, 0);
    gap = 1;
    while (ref_div !== 1'b1 && gap < 300) begin @(negedge clk); gap++; end
    chk("R2 ref_div period", gap, ratio);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    for (int m = 0; m < 2; m++) begin
      mode_pwl = m[0];
      t_lead(5);
      t_lead(1);
      t_lag(4);
      t_zero();
      t_idle();
    end
    t_period(R);
    t_period(10);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule